// File: doc/BRIEF.md
# Multi-format audio serial transmitter

The block turns 16-bit stereo PCM sample pairs into a three-wire serial audio stream made of a bit clock, a word clock that marks left and right, and a data line. Both clocks are divided down from the master clock. A two-field configuration input picks the framing and the number of bit clocks in each sample period. The supported framings are the I2S framing and a right-justified framing, in which the last data bit of each channel lines up with the end of its half-frame.

A sample pair is taken through a valid/ready handshake once per frame, at the frame boundary. If no pair is offered at that point, the frame is sent as silence and a sticky underflow flag is raised. Configuration is sampled only at frame boundaries, so the slot position and the data bit it carries are worked out again for the new framing and ratio from the first slot of the next frame.

Top module: `audio_ser_tx`

## Requirements
- R1: The bit clock toggles once every DIV_HALF master-clock cycles, so its period is 2*DIV_HALF cycles. While rst_ni is low, bclk_o, ws_o, sd_o, ready_o and underflow_o are all low.
- R2: sd_o and ws_o change only in the master-clock cycle in which bclk_o falls. A receiver can therefore sample both on the rising edge of the bit clock.
- R3: cfg_ratio_i selects the bit clocks per frame: 0 gives 32, 1 gives 48, and 2 or 3 give 64. In I2S mode, code 0 is raised to 48.
- R4: With cfg_fmt_i = 0 (I2S), ws_o is low for the left half-frame and high for the right half-frame. In each half, slot 0 is low, slots 1 to 16 carry the word MSB first, and the remaining slots are low.
- R5: With cfg_fmt_i = 1 (right-justified), ws_o is high for the left half-frame and low for the right half-frame. In each half, the word's LSB sits in the last slot and its MSB sits 15 slots earlier. The slots before the MSB are low.
- R6: ready_o is a single-cycle pulse issued once per frame, in the cycle just before the bit clock falls into slot 0. A pair presented with valid_i high in that cycle is sent in the frame that follows, left word in the first half.
- R7: If valid_i is low during the ready_o pulse, the following frame carries all-zero data words, with the normal word-clock pattern, and underflow_o goes high. underflow_o stays high until reset.
- R8: A change on cfg_fmt_i or cfg_ratio_i in the middle of a frame does not alter that frame. It takes effect at the next boundary, where the slot count starts again from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fmt_i | input | 1 | Framing select: 0 = I2S, 1 = right-justified |
| cfg_ratio_i | input | 2 | Bit clocks per frame: 0 = 32, 1 = 48, 2/3 = 64 |
| valid_i | input | 1 | A sample pair is offered |
| left_i | input | 16 | Left-channel sample |
| right_i | input | 16 | Right-channel sample |
| ready_o | output | 1 | Frame-boundary pulse; accepts the pair |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word clock (left/right) |
| sd_o | output | 1 | Serial data |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
The assertions check several properties on every cycle. The data and word-clock lines may move only on a falling bit-clock edge. The bit-clock half period stays within DIV_HALF cycles. The ready pulse lasts one cycle and comes just before a falling edge. The underflow flag never clears, and it rises only after a ready pulse that found no valid pair. The scoreboard scenarios cover what those properties cannot see. They rebuild every slot of every frame and compare the word-clock level and the data bit for each framing and ratio, including the promoted I2S 32 code and the reserved ratio code. They also show that a configuration change applied mid-frame is deferred to the next boundary, and that an underflowed frame comes out as zeros between normal frames.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

  localparam int unsigned SLOT_W = 6;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_RJ  = 1'b1
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] ratio;
  } cfg_t;

  // slots per half-frame; I2S cannot fit 16 bits after its lead slot at 32fs
  function automatic logic [SLOT_W-1:0] frame_half(cfg_t c);
    logic [SLOT_W-1:0] h;
    case (c.ratio)
      2'd0:    h = (c.fmt == FMT_I2S) ? SLOT_W'(24) : SLOT_W'(16);
      2'd1:    h = SLOT_W'(24);
      default: h = SLOT_W'(32);
    endcase
    return h;
  endfunction

  function automatic logic [SLOT_W-1:0] frame_last(cfg_t c);
    return SLOT_W'({1'b0, frame_half(c), 1'b0} - 1);
  endfunction

endpackage

// File: rtl/audio_bclk_gen.sv
module audio_bclk_gen #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bclk_o,
  output logic fall_o
);

  localparam int unsigned DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic tick;
  logic bclk_q;

  if (DIV_HALF == 1) begin : g_nodiv
    assign tick = 1'b1;
  end else begin : g_div
    logic [DW-1:0] dcnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   dcnt_q <= '0;
      else if (tick) dcnt_q <= '0;
      else           dcnt_q <= dcnt_q + 1'b1;
    end
    assign tick = (dcnt_q == DW'(DIV_HALF - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bclk_q <= 1'b0;
    else if (tick) bclk_q <= ~bclk_q;
  end

  assign bclk_o = bclk_q;
  // strobe in the cycle whose closing edge drops the bit clock
  assign fall_o = tick & bclk_q;

endmodule

// File: rtl/audio_frame_seq.sv
module audio_frame_seq
  import audio_ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  cfg_t              cfg_i,
  output logic              bound_o,
  output logic [SLOT_W-1:0] slot_nxt_o,
  output cfg_t              cfg_nxt_o
);

  localparam cfg_t CFG_RST = '{fmt: FMT_I2S, ratio: 2'd2};

  logic [SLOT_W-1:0] slot_q;
  cfg_t              cfg_q;

  // reset parks on the last slot so the first falling edge is a boundary
  assign bound_o    = step_i && (slot_q == frame_last(cfg_q));
  assign slot_nxt_o = bound_o ? '0 : slot_q + 1'b1;
  assign cfg_nxt_o  = bound_o ? cfg_i : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= frame_last(CFG_RST);
      cfg_q  <= CFG_RST;
    end else if (step_i) begin
      slot_q <= slot_nxt_o;
      cfg_q  <= cfg_nxt_o;
    end
  end

endmodule

// File: rtl/audio_bit_map.sv
module audio_bit_map
  import audio_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  cfg_t              cfg_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              ws_o,
  output logic              sd_o
);

  localparam int unsigned IW = $clog2(WORD_W);

  logic [SLOT_W-1:0] half;
  logic [SLOT_W-1:0] k;
  logic [SLOT_W-1:0] off;
  logic [IW-1:0]     idx;
  logic [WORD_W-1:0] word;
  logic              in_right;

  always_comb begin
    half     = frame_half(cfg_i);
    in_right = (slot_i >= half);
    k        = in_right ? (slot_i - half) : slot_i;
    word     = in_right ? right_i : left_i;
    off      = half - SLOT_W'(WORD_W);
    idx      = '0;
    sd_o     = 1'b0;
    if (cfg_i.fmt == FMT_I2S) begin
      ws_o = in_right;
      if (k >= SLOT_W'(1) && k <= SLOT_W'(WORD_W)) begin
        idx  = IW'(SLOT_W'(WORD_W) - k);
        sd_o = word[idx];
      end
    end else begin
      ws_o = ~in_right;
      if (k >= off) begin
        idx  = IW'(SLOT_W'(WORD_W - 1) - (k - off));
        sd_o = word[idx];
      end
    end
  end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_pkg::*;
#(
  parameter int unsigned DIV_HALF = 2,
  parameter int unsigned WORD_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_fmt_i,
  input  logic [1:0]        cfg_ratio_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              ready_o,
  output logic              bclk_o,
  output logic              ws_o,
  output logic              sd_o,
  output logic              underflow_o
);

  logic              fall;
  logic              bound;
  logic [SLOT_W-1:0] slot_nxt;
  cfg_t              cfg_in;
  cfg_t              cfg_nxt;
  logic [WORD_W-1:0] left_q, right_q, left_nxt, right_nxt;
  logic              ws_n, sd_n, ws_q, sd_q, uf_q;
  logic              take;

  assign cfg_in = '{fmt: fmt_e'(cfg_fmt_i), ratio: cfg_ratio_i};

  audio_bclk_gen #(.DIV_HALF(DIV_HALF)) u_bclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_o (bclk_o),
    .fall_o (fall)
  );

  audio_frame_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (fall),
    .cfg_i      (cfg_in),
    .bound_o    (bound),
    .slot_nxt_o (slot_nxt),
    .cfg_nxt_o  (cfg_nxt)
  );

  assign take      = bound & valid_i;
  assign left_nxt  = bound ? (take ? left_i  : '0) : left_q;
  assign right_nxt = bound ? (take ? right_i : '0) : right_q;

  audio_bit_map #(.WORD_W(WORD_W)) u_map (
    .cfg_i   (cfg_nxt),
    .slot_i  (slot_nxt),
    .left_i  (left_nxt),
    .right_i (right_nxt),
    .ws_o    (ws_n),
    .sd_o    (sd_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      right_q <= '0;
      ws_q    <= 1'b0;
      sd_q    <= 1'b0;
      uf_q    <= 1'b0;
    end else if (fall) begin
      left_q  <= left_nxt;
      right_q <= right_nxt;
      ws_q    <= ws_n;
      sd_q    <= sd_n;
      if (bound && !valid_i) uf_q <= 1'b1;
    end
  end

  assign ready_o     = bound;
  assign ws_o        = ws_q;
  assign sd_o        = sd_q;
  assign underflow_o = uf_q;

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter int unsigned DIV_HALF = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic bclk_o,
  input logic ws_o,
  input logic sd_o,
  input logic underflow_o
);

  localparam int unsigned RW = $clog2(DIV_HALF + 2) + 1;

  logic          bclk_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      run_q  <= '0;
    end else begin
      bclk_q <= bclk_o;
      if (bclk_o != bclk_q)               run_q <= '0;
      else if (run_q != RW'(DIV_HALF + 1)) run_q <= run_q + 1'b1;
    end
  end

  assert_bclk_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(DIV_HALF));

  assert_bclk_min_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclk_o != bclk_q) |-> (run_q >= RW'(DIV_HALF - 1)));

  assert_sd_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $fell(bclk_o));

  assert_ws_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(bclk_o));

  assert_ready_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> $fell(bclk_o));

  assert_ready_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_uf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  assert_uf_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> $past(ready_o && !valid_i));

endmodule

bind audio_ser_tx audio_ser_tx_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .ready_o     (ready_o),
  .bclk_o      (bclk_o),
  .ws_o        (ws_o),
  .sd_o        (sd_o),
  .underflow_o (underflow_o)
);

// File: tb/tb_audio_ser_tx.sv
`timescale 1ns/1ps
module tb_audio_ser_tx;

  localparam int DIV_HALF = 2;

  typedef struct {
    bit        fmt;
    int        f;
    bit [15:0] l;
    bit [15:0] r;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_fmt = 1'b0;
  logic [1:0]  cfg_ratio = 2'd2;
  logic        valid = 1'b0;
  logic [15:0] left = '0, right = '0;
  logic        ready_o, bclk_o, ws_o, sd_o, underflow_o;

  int    checks = 0, errors = 0;
  int    n_push = 0, n_done = 0;
  item_t sb_q[$];

  always #2 clk = ~clk;

  audio_ser_tx #(.DIV_HALF(DIV_HALF), .WORD_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_fmt_i(cfg_fmt), .cfg_ratio_i(cfg_ratio),
    .valid_i(valid), .left_i(left), .right_i(right), .ready_o(ready_o),
    .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o), .underflow_o(underflow_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input bit fmt, input bit [1:0] ratio);
    if (ratio == 2'd1) return 48;
    if (ratio == 2'd0) return fmt ? 32 : 48;
    return 64;
  endfunction

  function automatic void exp_slot(input item_t it, input int s, output bit ews, output bit esd);
    int        h  = it.f / 2;
    bit        rt = (s >= h);
    int        k  = rt ? s - h : s;
    bit [15:0] w  = rt ? it.r : it.l;
    int        off = h - 16;
    esd = 1'b0;
    if (!it.fmt) begin
      ews = rt;
      if (k >= 1 && k <= 16) esd = w[16-k];
    end else begin
      ews = !rt;
      if (k >= off) esd = w[15-(k-off)];
    end
  endfunction

  // driver: called at a negedge; returns at the negedge after acceptance
  task automatic send(input bit fmt, input bit [1:0] ratio, input bit [15:0] l,
                      input bit [15:0] r, input bit v);
    item_t it;
    cfg_fmt = fmt; cfg_ratio = ratio; left = l; right = r; valid = v;
    do @(negedge clk); while (!ready_o);
    @(posedge clk);
    it.fmt = fmt; it.f = eff_len(fmt, ratio);
    it.l = v ? l : 16'h0; it.r = v ? r : 16'h0;
    sb_q.push_back(it);
    n_push++;
    @(negedge clk);
    check("R6", "ready pulse width", int'(ready_o), 0);
  endtask

  // monitor: samples at the negedge after each bit-clock rise
  initial begin : monitor
    bit    prev = 1'b0, skip = 1'b1, active = 1'b0, stop = 1'b0;
    int    slot = 0, bad = 0, bad_slot = 0;
    bit    ews, esd, a_ws, a_sd, e_ws, e_sd;
    item_t cur;
    wait (rst_n);
    while (!stop) begin
      @(negedge clk);
      if (bclk_o && !prev) begin
        if (skip) skip = 1'b0;
        else begin
          if (slot == 0) begin
            if (sb_q.size() == 0) stop = 1'b1;
            else begin cur = sb_q.pop_front(); active = 1'b1; bad = 0; end
          end
          if (active) begin
            exp_slot(cur, slot, ews, esd);
            if ((ws_o !== ews) || (sd_o !== esd)) begin
              if (bad == 0) begin
                bad_slot = slot; a_ws = ws_o; a_sd = sd_o; e_ws = ews; e_sd = esd;
              end
              bad++;
            end
            slot++;
            if (slot == cur.f) begin
              checks++;
              if (bad != 0) begin
                errors++;
                $display("FAIL %s R3 R8 frame %0d slot %0d: actual ws=%0d sd=%0d expected ws=%0d sd=%0d",
                         cur.fmt ? "R5" : "R4", n_done, bad_slot, a_ws, a_sd, e_ws, e_sd);
              end
              n_done++;
              slot = 0;
              active = 1'b0;
            end
          end
        end
      end
      prev = bclk_o;
    end
  end

  // bit-clock period measurement (R1)
  initial begin : period_meas
    int rises = 0, t0 = 0, cyc = 0;
    bit p = 1'b0;
    wait (rst_n);
    while (rises < 3) begin
      @(negedge clk);
      cyc++;
      if (bclk_o && !p) begin
        rises++;
        if (rises == 2) t0 = cyc;
        if (rises == 3) check("R1", "bit clock period", cyc - t0, 2 * DIV_HALF);
      end
      p = bclk_o;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog: frames done %0d expected %0d", n_done, n_push);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1", "reset bclk", int'(bclk_o), 0);
    check("R1", "reset ws", int'(ws_o), 0);
    check("R1", "reset sd", int'(sd_o), 0);
    check("R1", "reset ready", int'(ready_o), 0);
    check("R1", "reset underflow", int'(underflow_o), 0);
    rst_n = 1'b1;
    // I2S at each ratio, including promoted code 0
    send(1'b0, 2'd2, 16'h8001, 16'h7FFE, 1'b1);
    send(1'b0, 2'd1, 16'hA5A5, 16'h5A5A, 1'b1);
    send(1'b0, 2'd0, 16'h1234, 16'hFEDC, 1'b1);
    send(1'b0, 2'd3, 16'hFFFF, 16'h0000, 1'b1);
    // right-justified at each ratio, including reserved code 3
    send(1'b1, 2'd0, 16'h8000, 16'h0001, 1'b1);
    send(1'b1, 2'd1, 16'hC3C3, 16'h3C3C, 1'b1);
    send(1'b1, 2'd2, 16'h0F0F, 16'hF0F0, 1'b1);
    send(1'b1, 2'd3, 16'h0000, 16'hFFFF, 1'b1);
    check("R7", "underflow before empty frame", int'(underflow_o), 0);
    // back to I2S 32-code after a right-justified 64 frame
    send(1'b0, 2'd0, 16'h4321, 16'h8765, 1'b1);
    send(1'b1, 2'd0, 16'hDEAD, 16'hBEEF, 1'b0);
    check("R7", "underflow after empty frame", int'(underflow_o), 1);
    send(1'b1, 2'd0, 16'h9ABC, 16'h1357, 1'b1);
    check("R7", "underflow sticky", int'(underflow_o), 1);
    send(1'b0, 2'd2, 16'h2468, 16'hACE0, 1'b1);
    wait (n_done == n_push);
    check("R6", "frames delivered", n_done, 12);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule